// File: doc/BRIEF.md
# Per-Element Leaky-Bucket Rate Shaper

This block holds a bank of independent shapers, one per scheduling element. Each shaper is a leaky bucket. A transmit report for an element pours into its bucket: the frame length in bytes in data mode, or a single count in frame mode. A leak strobe for an element drains the bucket by that element's committed-rate value, and the level never goes below zero. Leak strobes come from an external group timer, so the drain per strobe is already in group-resolution units. An element is eligible for transmission while its level does not exceed its committed burst, which is held in units of 64.

Software programs each element with one configuration word that holds the rate, the burst and the mode. A write whose burst lies outside the legal range is dropped, with one exception: a rate of zero together with a burst of zero is accepted and marks the element as unshaped, so it is always eligible. An accepted write empties that element's bucket. The scheduler reads the eligible vector directly.

Top module: `shp_leaky_bank`

## Requirements
- R1: After reset every element is unshaped (rate 0, burst 0, data mode, level 0), so all bits of `eligible` read 1.
- R2: An element whose configured rate and burst are both zero reads eligible regardless of any number of transmit reports.
- R3: In data mode (`cfg_frame_mode` = 0) a transmit report raises the element's level by `tx_len` bytes.
- R4: A shaped element is eligible exactly when its level is less than or equal to burst × 64; a level of burst × 64 is still eligible and one more is not.
- R5: A leak strobe lowers the element's level by its rate value, saturating at zero.
- R6: In frame mode (`cfg_frame_mode` = 1) a transmit report raises the level by one, whatever `tx_len` is.
- R7: An accepted configuration write sets the element's level to zero; it takes precedence over a transmit report or leak strobe to the same element in the same cycle.
- R8: A configuration write is rejected when its burst is outside 1..48 and the rate and burst are not both zero; a rejected write changes neither the element's configuration nor its level.
- R9: The level saturates at 8191 instead of wrapping.
- R10: When a transmit report and a leak strobe hit the same element in one cycle, the addition (saturated) is applied first and the drain second.
- R11: A report, strobe or write addressed to one element leaves every other element's eligibility unchanged.
- R12: `eligible` reflects an event after the first rising clock edge on which that event is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Element addressed by the write |
| cfg_rate | input | 12 | Committed rate, in drain units per leak strobe |
| cfg_burst | input | 6 | Committed burst, in units of 64 |
| cfg_frame_mode | input | 1 | 1 = count frames, 0 = count bytes |
| leak_vld | input | 1 | Leak strobe |
| leak_idx | input | 3 | Element drained by the strobe |
| tx_vld | input | 1 | Transmit report |
| tx_idx | input | 3 | Element charged by the report |
| tx_len | input | 12 | Frame length in bytes |
| eligible | output | 8 | Per-element eligibility |

## Verification
Each bucket level is visible only through one eligible bit. A wrong level therefore shows only when it crosses the burst threshold. The bench walks levels to the exact threshold and one past it. It also drives them into both saturation limits and then drains, so that a wrapped or mis-saturated level flips the bit on the next edge, not many events later. A wrong order of operations for a same-cycle report and strobe, or a write that is not dropped, shows on the element's bit one edge after the event. A leak to that element then exposes a corrupted rate one edge after that.

// File: rtl/shp_pkg.sv
package shp_pkg;

  typedef enum logic {
    SHP_BYTES  = 1'b0,
    SHP_FRAMES = 1'b1
  } shp_mode_e;

  function automatic int shp_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/shp_cfg_gate.sv
module shp_cfg_gate #(
  parameter int RATE_W    = 12,
  parameter int BURST_W   = 6,
  parameter int BURST_MIN = 1,
  parameter int BURST_MAX = 48
) (
  input  logic [RATE_W-1:0]  rate,
  input  logic [BURST_W-1:0] burst,
  output logic               accept
);
  logic is_off;
  logic in_range;

  always_comb begin
    is_off   = (rate == '0) && (burst == '0);
    in_range = (int'(burst) >= BURST_MIN) && (int'(burst) <= BURST_MAX);
    accept   = is_off || in_range;
  end
endmodule

// File: rtl/shp_bucket.sv
module shp_bucket
  import shp_pkg::*;
#(
  parameter int RATE_W    = 12,
  parameter int BURST_W   = 6,
  parameter int LEN_W     = 12,
  parameter int UNIT_LG2  = 6,
  parameter int LVL_W     = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_take,
  input  logic [RATE_W-1:0]  cfg_rate,
  input  logic [BURST_W-1:0] cfg_burst,
  input  shp_mode_e          cfg_mode,
  input  logic               leak_hit,
  input  logic               tx_hit,
  input  logic [LEN_W-1:0]   tx_len,
  output logic               eligible
);
  localparam int SUM_W = LVL_W + 1;
  localparam logic [SUM_W-1:0] LVL_TOP = {1'b0, {LVL_W{1'b1}}};

  logic [RATE_W-1:0]  rate_q;
  logic [BURST_W-1:0] burst_q;
  shp_mode_e          mode_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [LVL_W-1:0]   lvl_d;
  logic               lvl_en;

  logic [SUM_W-1:0]   add_amt;
  logic [SUM_W-1:0]   sub_amt;
  logic [SUM_W-1:0]   filled;
  logic [LVL_W-1:0]   thresh;

  // next-state: pour first (saturating high), then drain (saturating at zero)
  always_comb begin
    add_amt = '0;
    if (tx_hit) begin
      if (mode_q == SHP_FRAMES) add_amt = SUM_W'(1);
      else                      add_amt = SUM_W'(tx_len);
    end
    sub_amt = leak_hit ? SUM_W'(rate_q) : '0;
    filled  = {1'b0, lvl_q} + add_amt;
    if (filled > LVL_TOP) filled = LVL_TOP;
    if (cfg_take)              lvl_d = '0;
    else if (filled < sub_amt) lvl_d = '0;
    else                       lvl_d = LVL_W'(filled - sub_amt);
    lvl_en = cfg_take || tx_hit || leak_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= '0;
      burst_q <= '0;
      mode_q  <= SHP_BYTES;
    end else if (cfg_take) begin
      rate_q  <= cfg_rate;
      burst_q <= cfg_burst;
      mode_q  <= cfg_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_en) lvl_q <= lvl_d;
  end

  always_comb begin
    thresh   = LVL_W'({burst_q, {UNIT_LG2{1'b0}}});
    eligible = ((rate_q == '0) && (burst_q == '0)) || (lvl_q <= thresh);
  end
endmodule

// File: rtl/shp_leaky_bank.sv
module shp_leaky_bank
  import shp_pkg::*;
#(
  parameter int N_ELEM    = 8,
  parameter int RATE_W    = 12,
  parameter int BURST_W   = 6,
  parameter int LEN_W     = 12,
  parameter int UNIT_LG2  = 6,
  parameter int BURST_MIN = 1,
  parameter int BURST_MAX = 48,
  localparam int IDX_W    = (N_ELEM > 1) ? $clog2(N_ELEM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [RATE_W-1:0]  cfg_rate,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic               cfg_frame_mode,
  input  logic               leak_vld,
  input  logic [IDX_W-1:0]   leak_idx,
  input  logic               tx_vld,
  input  logic [IDX_W-1:0]   tx_idx,
  input  logic [LEN_W-1:0]   tx_len,
  output logic [N_ELEM-1:0]  eligible
);
  localparam int LVL_W = shp_max3(BURST_W + UNIT_LG2, LEN_W, RATE_W) + 1;

  logic rst_meta_q;
  logic rst_q;
  logic cfg_ok;
  shp_mode_e cfg_mode;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  shp_cfg_gate #(
    .RATE_W(RATE_W), .BURST_W(BURST_W),
    .BURST_MIN(BURST_MIN), .BURST_MAX(BURST_MAX)
  ) u_gate (
    .rate(cfg_rate), .burst(cfg_burst), .accept(cfg_ok)
  );

  assign cfg_mode = shp_mode_e'(cfg_frame_mode);

  for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
    logic take_e;
    logic leak_e;
    logic tx_e;

    always_comb begin
      take_e = cfg_we   && cfg_ok && (cfg_idx  == IDX_W'(e));
      leak_e = leak_vld && (leak_idx == IDX_W'(e));
      tx_e   = tx_vld   && (tx_idx   == IDX_W'(e));
    end

    shp_bucket #(
      .RATE_W(RATE_W), .BURST_W(BURST_W), .LEN_W(LEN_W),
      .UNIT_LG2(UNIT_LG2), .LVL_W(LVL_W)
    ) u_bucket (
      .clk(clk), .rst_n(rst_q),
      .cfg_take(take_e), .cfg_rate(cfg_rate), .cfg_burst(cfg_burst),
      .cfg_mode(cfg_mode), .leak_hit(leak_e), .tx_hit(tx_e),
      .tx_len(tx_len), .eligible(eligible[e])
    );
  end
endmodule

// File: rtl/shp_leaky_bank_chk.sv
module shp_leaky_bank_chk #(
  parameter int N_ELEM    = 8,
  parameter int IDX_W     = 3,
  parameter int RATE_W    = 12,
  parameter int BURST_W   = 6,
  parameter int BURST_MIN = 1,
  parameter int BURST_MAX = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [IDX_W-1:0]   cfg_idx,
  input logic [RATE_W-1:0]  cfg_rate,
  input logic [BURST_W-1:0] cfg_burst,
  input logic               leak_vld,
  input logic [IDX_W-1:0]   leak_idx,
  input logic               tx_vld,
  input logic [IDX_W-1:0]   tx_idx,
  input logic [N_ELEM-1:0]  eligible
);
  logic wr_off, wr_legal, wr_bad, wr_alone, leak_alone, tx_alone;

  always_comb begin
    wr_off     = cfg_we && (cfg_rate == '0) && (cfg_burst == '0);
    wr_legal   = cfg_we && (int'(cfg_burst) >= BURST_MIN) && (int'(cfg_burst) <= BURST_MAX);
    wr_bad     = cfg_we && !wr_off && !wr_legal;
    wr_alone   = !(tx_vld && tx_idx == cfg_idx) && !(leak_vld && leak_idx == cfg_idx);
    leak_alone = !(tx_vld && tx_idx == leak_idx) && !(cfg_we && cfg_idx == leak_idx);
    tx_alone   = !(leak_vld && leak_idx == tx_idx) && !(cfg_we && cfg_idx == tx_idx);
  end

  // R2: an element switched off is eligible on the next cycle
  a_r2_off_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off |=> eligible[$past(cfg_idx)]);

  // R7: accepted shaped write empties the bucket, so the element is eligible
  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_legal |=> eligible[$past(cfg_idx)]);

  // R8: a dropped write leaves the element alone
  a_r8_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bad && wr_alone) |=> (eligible[$past(cfg_idx)] == $past(eligible[cfg_idx])));

  // R5: a drain alone never removes eligibility
  a_r5_leak_no_block: assert property (@(posedge clk) disable iff (!rst_n)
    (leak_vld && leak_alone && eligible[leak_idx]) |=> eligible[$past(leak_idx)]);

  // R3: a report alone never grants eligibility
  a_r3_tx_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && tx_alone && !eligible[tx_idx]) |=> !eligible[$past(tx_idx)]);

  for (genvar e = 0; e < N_ELEM; e++) begin : g_idle
    // R11: an element not addressed by any event keeps its eligibility
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cfg_we && cfg_idx == IDX_W'(e)) && !(tx_vld && tx_idx == IDX_W'(e)) &&
       !(leak_vld && leak_idx == IDX_W'(e))) |=> $stable(eligible[e]));
  end
endmodule

bind shp_leaky_bank shp_leaky_bank_chk #(
  .N_ELEM(N_ELEM), .IDX_W(IDX_W), .RATE_W(RATE_W), .BURST_W(BURST_W),
  .BURST_MIN(BURST_MIN), .BURST_MAX(BURST_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_q), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
  .cfg_rate(cfg_rate), .cfg_burst(cfg_burst), .leak_vld(leak_vld),
  .leak_idx(leak_idx), .tx_vld(tx_vld), .tx_idx(tx_idx), .eligible(eligible)
);

// File: tb/shp_leaky_bank_tb.sv
module shp_leaky_bank_tb;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [11:0] cfg_rate;
  logic [5:0]  cfg_burst;
  logic        cfg_frame_mode;
  logic        leak_vld;
  logic [2:0]  leak_idx;
  logic        tx_vld;
  logic [2:0]  tx_idx;
  logic [11:0] tx_len;
  logic [7:0]  eligible;

  int checks;
  int failures;
  bit done;

  shp_leaky_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_rate(cfg_rate), .cfg_burst(cfg_burst), .cfg_frame_mode(cfg_frame_mode),
    .leak_vld(leak_vld), .leak_idx(leak_idx), .tx_vld(tx_vld), .tx_idx(tx_idx),
    .tx_len(tx_len), .eligible(eligible)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk_bit(input string req, input int idx, input logic expv);
    checks++;
    if (eligible[idx] !== expv) begin
      failures++;
      $display("FAIL %s: eligible[%0d] actual=%b expected=%b", req, idx, eligible[idx], expv);
    end
  endtask

  task automatic idle();
    cfg_we = 0; leak_vld = 0; tx_vld = 0;
  endtask

  // drive one cycle of stimulus at negedge, sample at the next negedge (R12)
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic do_cfg(input int idx, input int rate, input int burst, input bit frm);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_rate = 12'(rate);
    cfg_burst = 6'(burst); cfg_frame_mode = frm;
    step();
  endtask

  task automatic do_tx(input int idx, input int len);
    tx_vld = 1; tx_idx = 3'(idx); tx_len = 12'(len);
    step();
  endtask

  task automatic do_leak(input int idx);
    leak_vld = 1; leak_idx = 3'(idx);
    step();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) chk_bit("R1", i, 1'b1);
  endtask

  task automatic t_unshaped();
    do_cfg(2, 0, 0, 0);
    for (int k = 0; k < 4; k++) do_tx(2, 4000);
    chk_bit("R2", 2, 1'b1);
  endtask

  task automatic t_data_mode();
    do_cfg(1, 100, 2, 0);             // threshold 128
    do_tx(1, 100);  chk_bit("R3", 1, 1'b1);
    do_tx(1, 28);   chk_bit("R4 at threshold", 1, 1'b1);
    do_tx(1, 1);    chk_bit("R4 above threshold", 1, 1'b0);
    chk_bit("R11", 0, 1'b1);
    do_leak(1);     chk_bit("R5 drain", 1, 1'b1);       // 29
    do_leak(1);                                         // floor at 0
    do_tx(1, 128);  chk_bit("R5 floor", 1, 1'b1);       // 128
    do_tx(1, 1);    chk_bit("R4 reentry", 1, 1'b0);     // 129, kept for R8
  endtask

  task automatic t_reject();
    do_cfg(1, 5, 0, 0);   chk_bit("R8 burst below range", 1, 1'b0);
    do_cfg(1, 5, 60, 0);  chk_bit("R8 burst above range", 1, 1'b0);
    do_leak(1);           chk_bit("R8 rate kept", 1, 1'b1);   // 129-100=29
  endtask

  task automatic t_frame_mode();
    do_cfg(3, 1, 1, 1);   // threshold 64 frames
    for (int k = 0; k < 64; k++) do_tx(3, 4000);
    chk_bit("R6 at threshold", 3, 1'b1);
    do_tx(3, 4000);       chk_bit("R6 above threshold", 3, 1'b0);
    do_leak(3);           chk_bit("R6 drain", 3, 1'b1);
    do_tx(3, 1);          chk_bit("R6 refill", 3, 1'b0);
    do_cfg(3, 1, 1, 1);   chk_bit("R7 write clears", 3, 1'b1);
  endtask

  task automatic t_saturate();
    do_cfg(4, 4095, 48, 0);  // threshold 3072
    for (int k = 0; k < 3; k++) do_tx(4, 4095);
    chk_bit("R9 high", 4, 1'b0);
    do_leak(4);  chk_bit("R9 after one drain", 4, 1'b0);   // 4096
    do_leak(4);  chk_bit("R9 after two drains", 4, 1'b1);  // 1
  endtask

  task automatic t_same_cycle();
    do_cfg(5, 50, 1, 0);     // threshold 64
    tx_vld = 1; tx_idx = 3'd5; tx_len = 12'd100;
    leak_vld = 1; leak_idx = 3'd5;
    step();
    chk_bit("R10 pour then drain", 5, 1'b1);  // 50
    do_tx(5, 100); chk_bit("R10 level", 5, 1'b0);  // 150
    cfg_we = 1; cfg_idx = 3'd5; cfg_rate = 12'd50; cfg_burst = 6'd1; cfg_frame_mode = 0;
    tx_vld = 1; tx_idx = 3'd5; tx_len = 12'd1000;
    step();
    chk_bit("R7 write beats report", 5, 1'b1);
    do_tx(5, 65); chk_bit("R7 bucket empty", 5, 1'b0);
    chk_bit("R11", 6, 1'b1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0;
    idle();
    cfg_idx = 0; cfg_rate = 0; cfg_burst = 0; cfg_frame_mode = 0;
    leak_idx = 0; tx_idx = 0; tx_len = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unshaped();
    t_data_mode();
    t_reject();
    t_frame_mode();
    t_saturate();
    t_same_cycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule